// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block is a sum-of-products logic array whose personality is loaded while the chip runs. A set of single-bit logic inputs feeds an AND plane of product terms. Each term picks, for every input, whether the input appears true, appears complemented, or is left out. The terms then feed an OR plane that produces the outputs. A live mode input chooses between two topologies. In shared-term mode, any output may collect any term through a programmable connection row, so a term is built once and used by several outputs. In fixed-group mode, each output owns a hardwired group of four consecutive terms, and the connection rows play no part.

Software or a sequencer fills a shadow personality through a register-write port. One plane select bit chooses between a term row and an output row. A commit strobe then copies the whole shadow into the active personality on one clock edge, so the outputs never reflect a partly written configuration. From inputs to outputs the evaluation is purely combinational. After reset every connection is present, as in an unprogrammed array, so every term is blocked and every output is 0.

Top module: `pla_array`

## Requirements
- R1: Each input of a term row has a 2-bit code at cfgData bits [2i+1:2i]. Bit 0 set requires the input to be 1 and bit 1 set requires it to be 0. Code 00 leaves the input out of the term.
- R2: Code 11 holds both literals of one input, so the term is always 0. Reset loads every term code with 11 and every connection row with all ones, so outVec is 0 for any input until a commit.
- R3: A term whose inputs are all coded 00 evaluates to 1.
- R4: In shared-term mode (modePal=0), output m is the OR of every term p for which bit p of connection row m is 1. One term may feed several outputs.
- R5: In shared-term mode, an output whose connection row is all zeros is 0.
- R6: In fixed-group mode (modePal=1), output m is the OR of terms 4m to 4m+3, and the connection rows have no effect.
- R7: Writes change only the shadow copy. outVec does not change until cfgCommit is sampled high at a rising edge. From that edge on, the whole shadow is active.
- R8: A write whose index names no row of the selected plane (term index of NUM_TERMS or more, output index of NUM_OUTS or more) changes no row.
- R9: outVec follows dataIn and modePal in the same cycle, with no clock in the path.
- R10: cfgSel=0 writes term row cfgIdx from cfgData[2*NUM_IN-1:0]. cfgSel=1 writes connection row cfgIdx, where cfgData bit p connects term p. A single write never touches both planes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous active-low reset to the unprogrammed state |
| cfgWe | input | 1 | Write strobe for one shadow row |
| cfgSel | input | 1 | Plane select: 0 term row, 1 connection row |
| cfgIdx | input | IDX_W (4) | Row index within the selected plane |
| cfgData | input | DATA_W (16) | Row contents |
| cfgCommit | input | 1 | Copies the shadow personality into the active one |
| modePal | input | 1 | 0 shared-term topology, 1 fixed-group topology |
| dataIn | input | NUM_IN (4) | Logic inputs |
| outVec | output | NUM_OUTS (4) | Sum-of-products outputs |

## Verification
The hardest case to reach from the ports is an index outside the output plane. It only shows itself when a design folds it onto a real row. The stimulus therefore first commits an all-ignore term that is constant 1. It then writes an all-ones connection row at an index that aliases output 3 under truncation, commits, and confirms that the outputs still match the reference functions. Shadow isolation is shown by sampling the outputs after a full program but before the commit. Fixed-group mode is exercised with the shared-term connection rows still loaded, so any leak from those rows shows up on the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Strobes from the configuration control to the personality storage
  typedef struct packed {
    logic andWr;   // write one term row of the shadow
    logic orWr;    // write one connection row of the shadow
    logic commit;  // copy shadow into active personality
  } cfgStrobe_t;

  // Per-input literal codes of a term row
  localparam logic [1:0] LIT_SKIP  = 2'b00;
  localparam logic [1:0] LIT_TRUE  = 2'b01;
  localparam logic [1:0] LIT_COMP  = 2'b10;
  localparam logic [1:0] LIT_BLOCK = 2'b11;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl
  import pla_pkg::*;
#(
  parameter int NUM_TERMS = 16,
  parameter int NUM_OUTS  = 4,
  parameter int IDX_W     = 4
) (
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             cfgCommit,
  output cfgStrobe_t       strobe
);

  logic termInRange;
  logic outInRange;

  // Range checks keep foreign indices from folding onto real rows
  assign termInRange = (int'(cfgIdx) < NUM_TERMS);
  assign outInRange  = (int'(cfgIdx) < NUM_OUTS);

  always_comb begin
    strobe        = '0;
    strobe.andWr  = cfgWe && !cfgSel && termInRange;
    strobe.orWr   = cfgWe &&  cfgSel && outInRange;
    strobe.commit = cfgCommit;
  end

endmodule

// File: rtl/pla_personality.sv
module pla_personality
  import pla_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_TERMS = 16,
  parameter int NUM_OUTS  = 4,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  cfgStrobe_t                         strobe,
  input  logic [IDX_W-1:0]                   cfgIdx,
  input  logic [DATA_W-1:0]                  cfgData,
  input  logic [NUM_IN-1:0]                  dataIn,
  output logic [NUM_TERMS-1:0]               termVec,
  output logic [NUM_OUTS-1:0][NUM_TERMS-1:0] orRows
);

  localparam int ROW_W = 2 * NUM_IN;

  logic [NUM_TERMS-1:0][ROW_W-1:0]     shadowAnd;
  logic [NUM_TERMS-1:0][ROW_W-1:0]     activeAnd;
  logic [NUM_OUTS-1:0][NUM_TERMS-1:0]  shadowOr;
  logic [NUM_OUTS-1:0][NUM_TERMS-1:0]  activeOr;

  // Shadow rows: unprogrammed state has every connection present
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowAnd <= '1;
      shadowOr  <= '1;
    end else begin
      for (int p = 0; p < NUM_TERMS; p++) begin
        if (strobe.andWr && (cfgIdx == IDX_W'(p)))
          shadowAnd[p] <= cfgData[ROW_W-1:0];
      end
      for (int m = 0; m < NUM_OUTS; m++) begin
        if (strobe.orWr && (cfgIdx == IDX_W'(m)))
          shadowOr[m] <= cfgData[NUM_TERMS-1:0];
      end
    end
  end

  // Active personality: whole-array copy on commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeAnd <= '1;
      activeOr  <= '1;
    end else if (strobe.commit) begin
      activeAnd <= shadowAnd;
      activeOr  <= shadowOr;
    end
  end

  // AND plane: each literal either passes or blocks the term
  for (genvar p = 0; p < NUM_TERMS; p++) begin : g_term
    logic [NUM_IN-1:0] litOk;
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
      logic [1:0] code;
      assign code     = activeAnd[p][2*i +: 2];
      assign litOk[i] = (!code[0] || dataIn[i]) && (!code[1] || !dataIn[i]);
    end
    assign termVec[p] = &litOk;
  end

  assign orRows = activeOr;

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NUM_TERMS     = 16,
  parameter int NUM_OUTS      = 4,
  parameter int TERMS_PER_OUT = 4
) (
  input  logic                               modePal,
  input  logic [NUM_TERMS-1:0]               termVec,
  input  logic [NUM_OUTS-1:0][NUM_TERMS-1:0] orRows,
  output logic [NUM_OUTS-1:0]                outVec
);

  for (genvar m = 0; m < NUM_OUTS; m++) begin : g_out
    logic sharedHit;
    logic groupHit;
    // Shared-term topology: programmable connection row
    assign sharedHit = |(termVec & orRows[m]);
    // Fixed-group topology: hardwired private group of terms
    assign groupHit  = |termVec[m*TERMS_PER_OUT +: TERMS_PER_OUT];
    assign outVec[m] = modePal ? groupHit : sharedHit;
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int NUM_IN        = 4,
  parameter int NUM_TERMS     = 16,
  parameter int NUM_OUTS      = 4,
  parameter int TERMS_PER_OUT = 4,
  parameter int IDX_W         = $clog2(maxOf(NUM_TERMS, NUM_OUTS)),
  parameter int DATA_W        = maxOf(2 * NUM_IN, NUM_TERMS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              cfgCommit,
  input  logic              modePal,
  input  logic [NUM_IN-1:0] dataIn,
  output logic [NUM_OUTS-1:0] outVec
);

  cfgStrobe_t                         strobe;
  logic [NUM_TERMS-1:0]               termVec;
  logic [NUM_OUTS-1:0][NUM_TERMS-1:0] orRows;

  pla_cfg_ctrl #(
    .NUM_TERMS(NUM_TERMS), .NUM_OUTS(NUM_OUTS), .IDX_W(IDX_W)
  ) u_ctrl (
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgCommit(cfgCommit), .strobe(strobe)
  );

  pla_personality #(
    .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUTS(NUM_OUTS),
    .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_pers (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .dataIn(dataIn), .termVec(termVec), .orRows(orRows)
  );

  pla_or_plane #(
    .NUM_TERMS(NUM_TERMS), .NUM_OUTS(NUM_OUTS), .TERMS_PER_OUT(TERMS_PER_OUT)
  ) u_or (
    .modePal(modePal), .termVec(termVec), .orRows(orRows), .outVec(outVec)
  );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk
  import pla_pkg::*;
#(
  parameter int NUM_IN        = 4,
  parameter int NUM_TERMS     = 16,
  parameter int NUM_OUTS      = 4,
  parameter int TERMS_PER_OUT = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgCommit,
  input logic                 modePal,
  input logic [NUM_IN-1:0]    dataIn,
  input logic [NUM_OUTS-1:0]  outVec,
  input logic [NUM_TERMS-1:0] termVec,
  input cfgStrobe_t           strobe
);

  // R2: reset leaves every output low
  p_reset_clear_r2: assert property (@(posedge clk)
    !rstN |=> (outVec == '0));

  // R7: without a commit and with steady inputs the outputs hold
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgCommit) && $stable(dataIn) && $stable(modePal)) |-> $stable(outVec));

  // R4: no live term means no live output in either topology
  p_no_term_r4: assert property (@(posedge clk) disable iff (!rstN)
    (termVec == '0) |-> (outVec == '0));

  // R10: one write reaches at most one plane
  p_one_plane_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.andWr, strobe.orWr}));

  // R6: in fixed-group mode an output needs a live term of its own group
  for (genvar m = 0; m < NUM_OUTS; m++) begin : g_grp
    p_group_r6: assert property (@(posedge clk) disable iff (!rstN)
      (modePal && (termVec[m*TERMS_PER_OUT +: TERMS_PER_OUT] == '0)) |-> !outVec[m]);
  end

endmodule

bind pla_array pla_array_chk #(
  .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS),
  .NUM_OUTS(NUM_OUTS), .TERMS_PER_OUT(TERMS_PER_OUT)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgCommit(cfgCommit), .modePal(modePal),
  .dataIn(dataIn), .outVec(outVec), .termVec(termVec), .strobe(strobe)
);

// File: tb/sim_pla_array.sv
module sim_pla_array;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [3:0]  cfgIdx = '0;
  logic [15:0] cfgData = '0;
  logic        cfgCommit = 1'b0;
  logic        modePal = 1'b0;
  logic [3:0]  dataIn = '0;
  logic [3:0]  outVec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pla_array u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .cfgCommit(cfgCommit), .modePal(modePal),
    .dataIn(dataIn), .outVec(outVec)
  );

  // Reference results {F3,F2,F1,F0} indexed by {A,B,C}
  // F0=A+B'C'  F1=AC'+AB  F2=B'C'+AB  F3=B'C+A
  localparam logic [3:0] PLA_EXP [8] = '{4'h5, 4'h8, 4'h0, 4'h0,
                                         4'hF, 4'h9, 4'hF, 4'hF};

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (in=%b pal=%b)", req, act, exp, dataIn, modePal);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [3:0] idx, input logic [15:0] dat);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = idx; cfgData = dat;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfgCommit = 1'b1;
    @(negedge clk);
    cfgCommit = 1'b0;
  endtask

  task automatic apply(input logic pal, input logic [3:0] inVal);
    modePal = pal; dataIn = inVal;
    #1;
  endtask

  function automatic logic [3:0] palExp(input logic [3:0] v, input logic grp2);
    logic a, b, c;
    a = v[2]; b = v[1]; c = v[0];
    return {1'b0, grp2, (!b && c), (a || (!b && !c))};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: unprogrammed array gives 0 in both topologies
    for (int v = 0; v < 16; v++) begin
      apply(1'b0, 4'(v)); check("R2 reset shared", outVec, 4'h0);
      apply(1'b1, 4'(v)); check("R2 reset group", outVec, 4'h0);
    end

    // R1/R10: term rows, A=in[2], B=in[1], C=in[0], in[3] skipped
    cfgWrite(1'b0, 4'd0, 16'h0010); // A
    cfgWrite(1'b0, 4'd1, 16'h000A); // B'C'
    cfgWrite(1'b0, 4'd2, 16'h0012); // AC'
    cfgWrite(1'b0, 4'd3, 16'h0014); // AB
    cfgWrite(1'b0, 4'd4, 16'h0009); // B'C
    cfgWrite(1'b1, 4'd0, 16'h0003);
    cfgWrite(1'b1, 4'd1, 16'h000C);
    cfgWrite(1'b1, 4'd2, 16'h000A);
    cfgWrite(1'b1, 4'd3, 16'h0011);

    // R7: nothing visible before the commit
    apply(1'b0, 4'b0100); check("R7 before commit", outVec, 4'h0);
    commit();

    // R4/R1/R9: all inputs, in[3] toggled and must not matter
    for (int v = 0; v < 16; v++) begin
      apply(1'b0, 4'(v));
      check("R4 shared table", outVec, PLA_EXP[v % 8]);
    end

    // R6: fixed groups, connection rows still loaded
    for (int v = 0; v < 8; v++) begin
      apply(1'b1, 4'(v));
      check("R6 group table", outVec, palExp(4'(v), 1'b0));
    end

    // R3: term 8 all skipped -> constant 1 in group 2
    cfgWrite(1'b0, 4'd8, 16'h0000);
    commit();
    for (int v = 0; v < 8; v++) begin
      apply(1'b1, 4'(v));
      check("R3 all-skip term", outVec, palExp(4'(v), 1'b1));
    end
    apply(1'b0, 4'b0010); check("R3 shared unaffected", outVec, 4'h0);

    // R8: connection index 7 does not exist and must not alias
    cfgWrite(1'b1, 4'd7, 16'hFFFF);
    commit();
    for (int v = 0; v < 8; v++) begin
      apply(1'b0, 4'(v));
      check("R8 bad index ignored", outVec, PLA_EXP[v]);
    end

    // R5: empty connection row for output 3
    cfgWrite(1'b1, 4'd3, 16'h0000);
    commit();
    apply(1'b0, 4'b0100); check("R5 empty row", outVec, 4'h7);
    apply(1'b0, 4'b0001); check("R5 empty row", outVec, 4'h0);

    // R10: connection row 0 now only term 8
    cfgWrite(1'b1, 4'd0, 16'h0100);
    commit();
    apply(1'b0, 4'b0010); check("R10 row routing", outVec, 4'h1);
    apply(1'b0, 4'b0100); check("R10 row routing", outVec, 4'h7);

    // R2: reset again clears the programmed personality
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    apply(1'b0, 4'b0100); check("R2 re-reset", outVec, 4'h0);
    rstN = 1'b1;
    @(negedge clk);
    apply(1'b1, 4'b0100); check("R2 re-reset group", outVec, 4'h0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule